// File: doc/BRIEF.md
# UART FIFO Service Request Logic

This block holds the transmit and receive character queues of a UART and turns their fill state into the signals that software and a DMA engine act on. The serial side pushes received characters and pops characters to transmit. The host side pops received characters and pushes characters to send. From the two occupancy counts the block derives a receive DMA request, a transmit DMA request, interrupt lines, and the two status bits a polling driver reads: data ready and transmit holding empty.

The receive request fires when occupancy reaches a programmable trigger level. It also fires after the receive line has been idle for a few character times while bytes are still waiting, so a remainder smaller than the trigger can still be collected. The DMA engine sees the exact 7-bit occupancy and can move precisely that many bytes.

Clearing the FIFO enable reduces each queue to a single holding register. Clearing the interrupt enables of one direction while the FIFOs stay on puts that direction into polled operation.

Top module: `uart_fifo_svc`

## Requirements
- R1: Each queue holds 64 bytes in arrival order, and its count reads 0 to 64. An accepted push raises the count by one, an accepted pop lowers it by one, and a push and a pop together leave it unchanged. The pop data port always shows the oldest entry (show-ahead), and the count changes one clock edge after the request.
- R2: A pop from an empty queue is ignored. A transmit push into a full queue is dropped and the count stays unchanged.
- R3: A receive push into a full queue with no pop in the same cycle is dropped and sets a sticky `overrun` flag. A `stat_rd` pulse clears the flag. If a drop and `stat_rd` occur in the same cycle, the flag stays set.
- R4: `trig_sel` selects the receive trigger level: 0 gives 1, 1 gives 16, 2 gives 32 and 3 gives 56 entries. `rx_dma_req` is high while `rx_count` is at or above that level.
- R5: If `rx_count` is non-zero and 4 `char_tick` pulses arrive with no receive push and no accepted receive pop, `rx_dma_req` goes high. Any receive push or accepted pop restarts the idle count. `rx_dma_req` is never high while `rx_count` is 0.
- R6: `data_ready` is high exactly while `rx_count` is non-zero.
- R7: `thr_empty` is high exactly while `tx_count` is 0. `tx_dma_req` is high while `tx_count` is below the queue capacity.
- R8: With `fifo_en` low, the capacity of both queues is 1 and the receive trigger level is 1.
- R9: `irq_en` bit 0 enables the receive-data interrupt, bit 1 the transmit-empty interrupt, and bit 2 the line-error interrupt. `rx_polled` = `fifo_en` and bits 0 and 2 both clear. `tx_polled` = `fifo_en` and bit 1 clear.
- R10: `rx_irq` = (bit 0 and `rx_dma_req`) or (bit 2 and `overrun`). `tx_irq` = bit 1 and `thr_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: 64-deep queues; 0: single holding register |
| trig_sel | input | 2 | Receive trigger level code |
| irq_en | input | 3 | Interrupt enables: rx data, tx empty, line error |
| stat_rd | input | 1 | Status read strobe; clears overrun |
| char_tick | input | 1 | One pulse per character time |
| rx_push | input | 1 | Received character strobe |
| rx_push_data | input | 8 | Received character |
| rx_pop | input | 1 | Host takes a received character |
| rx_pop_data | output | 8 | Oldest received character |
| tx_push | input | 1 | Host supplies a character |
| tx_push_data | input | 8 | Character to send |
| tx_pop | input | 1 | Shifter takes a character |
| tx_pop_data | output | 8 | Oldest character to send |
| rx_count | output | 7 | Receive occupancy |
| tx_count | output | 7 | Transmit occupancy |
| data_ready | output | 1 | Receive data available |
| thr_empty | output | 1 | Transmitter needs data |
| overrun | output | 1 | Sticky receive drop flag |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |
| rx_polled | output | 1 | Receive direction in polled mode |
| tx_polled | output | 1 | Transmit direction in polled mode |

## Verification
Every status and request output is a combinational decode of registered counts, flags and the current configuration inputs. The effect of a push, pop, tick or status read is therefore due one rising edge after the request, while a configuration change shows at once. The bench drives each stimulus on a falling edge, updates its model at the next rising edge and compares all outputs on the following falling edge. Pop data is show-ahead, so it is compared in the same cycle the pop is requested, before the edge that consumes it.

// File: rtl/usvc_pkg.sv
package usvc_pkg;

   typedef enum logic [1:0] {
      TRIG_CODE_MIN  = 2'd0,
      TRIG_CODE_LOW  = 2'd1,
      TRIG_CODE_MID  = 2'd2,
      TRIG_CODE_HIGH = 2'd3
   } trig_code_e;

   typedef struct packed {
      logic line_err;
      logic tx_space;
      logic rx_avail;
   } svc_ien_t;

endpackage

// File: rtl/usvc_fifo.sv
module usvc_fifo #(
   parameter  int DEPTH = 64,
   parameter  int DW    = 8,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cap,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] pop_data,
   output logic [CW-1:0] count,
   output logic          pop_ok,
   output logic          push_drop
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("usvc_fifo: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("usvc_fifo: DW must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok;

   if (DEPTH == (1 << AW)) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign pop_ok    = pop && (count != '0);
   assign push_ok   = push && ((count < cap) || pop_ok);
   assign push_drop = push && !push_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   assign pop_data = mem[rd_ptr];

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R1
   AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !push_drop && !pop_ok) |=> count == $past(count) + 1'b1); // R1
   AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && !push) |=> count == $past(count) - 1'b1); // R1
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count == '0 && !push) |=> count == '0); // R2

endmodule

// File: rtl/usvc_rx_svc.sv
module usvc_rx_svc
   import usvc_pkg::*;
#(
   parameter  int DEPTH      = 64,
   parameter  int TRIG_LVL0  = 1,
   parameter  int TRIG_LVL1  = 16,
   parameter  int TRIG_LVL2  = 32,
   parameter  int TRIG_LVL3  = 56,
   parameter  int IDLE_CHARS = 4,
   localparam int CW         = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic [1:0]    trig_sel,
   input  logic [CW-1:0] count,
   input  logic          char_arrive,
   input  logic          pop_ok,
   input  logic          push_drop,
   input  logic          char_tick,
   input  logic          stat_rd,
   output logic          dma_req,
   output logic          overrun
);

   if (TRIG_LVL0 < 1 || TRIG_LVL0 > DEPTH || TRIG_LVL1 < 1 || TRIG_LVL1 > DEPTH ||
       TRIG_LVL2 < 1 || TRIG_LVL2 > DEPTH || TRIG_LVL3 < 1 || TRIG_LVL3 > DEPTH) begin : g_bad_lvl
      $error("usvc_rx_svc: trigger levels must lie in 1..DEPTH");
   end
   if (IDLE_CHARS < 0) begin : g_bad_idle
      $error("usvc_rx_svc: IDLE_CHARS must not be negative");
   end

   logic [CW-1:0] level;
   logic          idle_hit;

   always_comb begin
      if (!fifo_en) begin
         level = CW'(1);
      end else begin
         unique case (trig_code_e'(trig_sel))
            TRIG_CODE_MIN:  level = CW'(TRIG_LVL0);
            TRIG_CODE_LOW:  level = CW'(TRIG_LVL1);
            TRIG_CODE_MID:  level = CW'(TRIG_LVL2);
            TRIG_CODE_HIGH: level = CW'(TRIG_LVL3);
         endcase
      end
   end

   if (IDLE_CHARS > 0) begin : g_idle
      localparam int TW = $clog2(IDLE_CHARS + 1);
      logic [TW-1:0] idle_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idle_q <= '0;
         end else if (char_arrive || pop_ok) begin
            idle_q <= '0;
         end else if (char_tick && idle_q != TW'(IDLE_CHARS)) begin
            idle_q <= idle_q + 1'b1;
         end
      end
      assign idle_hit = (idle_q == TW'(IDLE_CHARS));
   end else begin : g_no_idle
      assign idle_hit = 1'b0;
   end

   assign dma_req = (count >= level) || (idle_hit && count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun <= 1'b0;
      end else if (push_drop) begin
         overrun <= 1'b1;
      end else if (stat_rd) begin
         overrun <= 1'b0;
      end
   end

   AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> !dma_req); // R5
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      push_drop |=> overrun); // R3
   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !stat_rd) |=> overrun); // R3
   AST_OVR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !push_drop) |=> !overrun); // R3

endmodule

// File: rtl/usvc_tx_svc.sv
module usvc_tx_svc #(
   parameter  int DEPTH = 64,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] cap,
   output logic          thr_empty,
   output logic          dma_req
);

   assign thr_empty = (count == '0);
   assign dma_req   = (count < cap);

   AST_EMPTY_HAS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      thr_empty |-> dma_req); // R7

endmodule

// File: rtl/uart_fifo_svc.sv
module uart_fifo_svc
   import usvc_pkg::*;
#(
   parameter  int DEPTH      = 64,
   parameter  int DW         = 8,
   parameter  int TRIG_LVL0  = 1,
   parameter  int TRIG_LVL1  = 16,
   parameter  int TRIG_LVL2  = 32,
   parameter  int TRIG_LVL3  = 56,
   parameter  int IDLE_CHARS = 4,
   localparam int CW         = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic [1:0]    trig_sel,
   input  logic [2:0]    irq_en,
   input  logic          stat_rd,
   input  logic          char_tick,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_push_data,
   input  logic          rx_pop,
   output logic [DW-1:0] rx_pop_data,
   input  logic          tx_push,
   input  logic [DW-1:0] tx_push_data,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_pop_data,
   output logic [CW-1:0] rx_count,
   output logic [CW-1:0] tx_count,
   output logic          data_ready,
   output logic          thr_empty,
   output logic          overrun,
   output logic          rx_dma_req,
   output logic          tx_dma_req,
   output logic          rx_irq,
   output logic          tx_irq,
   output logic          rx_polled,
   output logic          tx_polled
);

   svc_ien_t      ien;
   logic [CW-1:0] cap;
   logic          rx_pop_ok, rx_drop, tx_pop_ok, tx_drop;

   assign ien = svc_ien_t'(irq_en);
   assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

   usvc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .cap(cap),
      .push(rx_push), .push_data(rx_push_data),
      .pop(rx_pop), .pop_data(rx_pop_data),
      .count(rx_count), .pop_ok(rx_pop_ok), .push_drop(rx_drop)
   );

   usvc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .cap(cap),
      .push(tx_push), .push_data(tx_push_data),
      .pop(tx_pop), .pop_data(tx_pop_data),
      .count(tx_count), .pop_ok(tx_pop_ok), .push_drop(tx_drop)
   );

   usvc_rx_svc #(
      .DEPTH(DEPTH), .TRIG_LVL0(TRIG_LVL0), .TRIG_LVL1(TRIG_LVL1),
      .TRIG_LVL2(TRIG_LVL2), .TRIG_LVL3(TRIG_LVL3), .IDLE_CHARS(IDLE_CHARS)
   ) u_rx_svc (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
      .count(rx_count), .char_arrive(rx_push), .pop_ok(rx_pop_ok),
      .push_drop(rx_drop), .char_tick(char_tick), .stat_rd(stat_rd),
      .dma_req(rx_dma_req), .overrun(overrun)
   );

   usvc_tx_svc #(.DEPTH(DEPTH)) u_tx_svc (
      .clk(clk), .rst_n(rst_n), .count(tx_count), .cap(cap),
      .thr_empty(thr_empty), .dma_req(tx_dma_req)
   );

   assign data_ready = (rx_count != '0);
   assign rx_polled  = fifo_en && !ien.rx_avail && !ien.line_err;
   assign tx_polled  = fifo_en && !ien.tx_space;
   assign rx_irq     = (ien.rx_avail && rx_dma_req) || (ien.line_err && overrun);
   assign tx_irq     = ien.tx_space && thr_empty;

   AST_TX_DROP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      tx_drop |=> tx_count == $past(tx_count)); // R2
   AST_TX_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop_ok && !tx_push) |=> tx_count == $past(tx_count) - 1'b1); // R1
   AST_RX_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_polled |-> !rx_irq); // R9
   AST_TX_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> (tx_count == '0)); // R10
   AST_DR_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |-> data_ready); // R6

endmodule

// File: tb/tb_uart_fifo_svc.sv
module tb_uart_fifo_svc;

   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fifo_en, stat_rd, char_tick;
   logic [1:0] trig_sel;
   logic [2:0] irq_en;
   logic       rx_push, rx_pop, tx_push, tx_pop;
   logic [7:0] rx_push_data, rx_pop_data, tx_push_data, tx_pop_data;
   logic [6:0] rx_count, tx_count;
   logic       data_ready, thr_empty, overrun, rx_dma_req, tx_dma_req;
   logic       rx_irq, tx_irq, rx_polled, tx_polled;

   always #4 clk = ~clk;

   uart_fifo_svc dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
      .irq_en(irq_en), .stat_rd(stat_rd), .char_tick(char_tick),
      .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
      .rx_pop_data(rx_pop_data), .tx_push(tx_push), .tx_push_data(tx_push_data),
      .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .rx_count(rx_count),
      .tx_count(tx_count), .data_ready(data_ready), .thr_empty(thr_empty),
      .overrun(overrun), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
      .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_polled(rx_polled), .tx_polled(tx_polled)
   );

   int       n_chk = 0;
   int       n_err = 0;
   bit       done  = 0;
   logic [7:0] rq[$];
   logic [7:0] tq[$];
   bit       ovr;
   int       idle;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_level();
      if (!fifo_en) return 1;
      case (trig_sel)
         2'd0:    return 1;
         2'd1:    return 16;
         2'd2:    return 32;
         default: return 56;
      endcase
   endfunction

   function automatic int exp_cap();
      return fifo_en ? DEPTH : 1;
   endfunction

   task automatic check_all();
      int  rs  = rq.size();
      int  ts  = tq.size();
      bit  req = (rs >= exp_level()) || (rs != 0 && idle == 4);
      chk("R1", "rx_count", int'(rx_count), rs);
      chk("R1", "tx_count", int'(tx_count), ts);
      chk("R6", "data_ready", int'(data_ready), int'(rs != 0));
      chk("R7", "thr_empty", int'(thr_empty), int'(ts == 0));
      chk(fifo_en ? "R7" : "R8", "tx_dma_req", int'(tx_dma_req), int'(ts < exp_cap()));
      chk("R3", "overrun", int'(overrun), int'(ovr));
      chk((rs >= exp_level()) ? "R4" : "R5", "rx_dma_req", int'(rx_dma_req), int'(req));
      chk("R9", "rx_polled", int'(rx_polled), int'(fifo_en && !irq_en[0] && !irq_en[2]));
      chk("R9", "tx_polled", int'(tx_polled), int'(fifo_en && !irq_en[1]));
      chk("R10", "rx_irq", int'(rx_irq), int'((irq_en[0] && req) || (irq_en[2] && ovr)));
      chk("R10", "tx_irq", int'(tx_irq), int'(irq_en[1] && ts == 0));
   endtask

   task automatic cyc(input bit rp, input bit rpo, input bit tp, input bit tpo,
                      input bit tick, input bit srd);
      bit r_pop_ok, r_push_ok, t_pop_ok, t_push_ok;
      logic [7:0] rd, td;
      rd = 8'($urandom);
      td = 8'($urandom);
      rx_push = rp; rx_push_data = rd; rx_pop = rpo;
      tx_push = tp; tx_push_data = td; tx_pop = tpo;
      char_tick = tick; stat_rd = srd;
      #1;
      if (rpo && rq.size() != 0) chk("R1", "rx_pop_data", int'(rx_pop_data), int'(rq[0]));
      if (tpo && tq.size() != 0) chk("R1", "tx_pop_data", int'(tx_pop_data), int'(tq[0]));
      @(posedge clk);
      r_pop_ok  = rpo && rq.size() != 0;
      r_push_ok = rp && (rq.size() < exp_cap() || r_pop_ok);
      t_pop_ok  = tpo && tq.size() != 0;
      t_push_ok = tp && (tq.size() < exp_cap() || t_pop_ok);
      if (rp && !r_push_ok) ovr = 1;
      else if (srd) ovr = 0;
      if (rp || r_pop_ok) idle = 0;
      else if (tick && idle < 4) idle++;
      if (r_pop_ok) void'(rq.pop_front());
      if (r_push_ok) rq.push_back(rd);
      if (t_pop_ok) void'(tq.pop_front());
      if (t_push_ok) tq.push_back(td);
      @(negedge clk);
      check_all();
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; fifo_en = 1'b1; trig_sel = 2'd0; irq_en = 3'd0;
      stat_rd = 0; char_tick = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
      rx_push_data = 0; tx_push_data = 0;
      ovr = 0; idle = 0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_all();  // reset state: R1 R6 R7

      // R1 ordering through both queues
      for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 0, 0);
      for (int i = 0; i < 5; i++) cyc(0, 1, 0, 1, 0, 0);

      // R2: overfill transmit queue, then drain past empty
      for (int i = 0; i < DEPTH + 3; i++) cyc(0, 0, 1, 0, 0, 0);
      for (int i = 0; i < DEPTH + 3; i++) cyc(0, 0, 0, 1, 0, 0);

      // R4 and R3: fill receive queue at the highest trigger, overflow, clear
      trig_sel = 2'd3; irq_en = 3'b101;
      for (int i = 0; i < DEPTH + 2; i++) cyc(1, 0, 0, 0, 0, 0);
      cyc(1, 1, 0, 0, 0, 0);   // full with pop: no drop
      cyc(1, 0, 0, 0, 0, 1);   // drop and read together: R3 stays set
      cyc(0, 0, 0, 0, 0, 1);   // read clears
      for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, 0, 0, 0);

      // R5: idle timeout below the trigger
      trig_sel = 2'd1;
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0);
      cyc(0, 1, 0, 0, 0, 0);   // accepted pop restarts idle count
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0);
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 1, 0);

      // R8: single holding register
      fifo_en = 1'b0;
      cyc(1, 0, 1, 0, 0, 0);
      cyc(1, 0, 1, 0, 0, 0);
      cyc(0, 1, 0, 1, 0, 1);
      fifo_en = 1'b1;

      // R9 R10: every enable pattern with and without FIFOs
      for (int e = 0; e < 16; e++) begin
         irq_en = 3'(e); fifo_en = e[3];
         cyc(e[0], 0, 0, e[1], 0, 0);
      end
      fifo_en = 1'b1;

      // constrained random phases
      for (int ph = 0; ph < 12; ph++) begin
         int bias = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 20 : 50;
         for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 40) == 0) trig_sel = 2'($urandom);
            if ($urandom_range(0, 30) == 0) irq_en = 3'($urandom);
            if ($urandom_range(0, 150) == 0) fifo_en = ~fifo_en;
            cyc($urandom_range(0, 99) < bias, $urandom_range(0, 99) >= bias,
                $urandom_range(0, 99) < bias, $urandom_range(0, 99) >= bias,
                $urandom_range(0, 2) == 0, $urandom_range(0, 15) == 0);
         end
      end

      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule